// File: doc/BRIEF.md
# MII Management Front End with PHY Register Model

This block gives a host a small set of registers for driving MII management transactions. A companion register file models a single PHY. The host first loads an address register with a PHY address and a register index. It can then push 16-bit control data into the PHY, fetch a PHY register into a receive-data register, or enable link scanning. Every transaction completes in one clock. No serial MDC/MDIO timing is modelled.

The PHY model responds at one PHY address only. It comes out of reset with fixed default values and treats its two identifier registers as read-only. It follows a `link_ok` input in two places: its basic status register and its link-partner ability register. The host front end keeps a link-failure flag. That flag is refreshed whenever a command is issued, and also on every link change while scanning is enabled.

Top module: `mgmt_phy_regs`

## Requirements
- R1: Host registers are selected by `host_sel`: 0 mode, 1 command, 2 address, 3 transmit data, 4 receive data, 5 status; 6 and 7 read zero. After reset, mode reads 0x64 and every other host register reads zero.
- R2: The address register holds the PHY address in bits 4:0 and the PHY register index in bits 12:8. All other bits read zero.
- R3: After reset the PHY registers read as follows: index 0 is 0x1000, 1 is 0x7848, 2 is 0x2000, 3 is 0x5C90, 4 is 0x01E1, and every other index is 0, with the link down.
- R4: Writing the command register with bit 1 set loads the receive-data register. If the PHY address is 1, it receives the addressed PHY register; for any other PHY address it receives 0xFFFF.
- R5: One cycle after `link_ok` rises, bit 2 of PHY register 1 is set and register 5 is ORed with 0x01E1. One cycle after `link_ok` falls, bit 2 of PHY register 1 is cleared and register 5 is ANDed with 0x01FF.
- R6: Writing the transmit-data register stores its low 16 bits. In the same cycle the value is written to the addressed PHY register, but only when the PHY address is 1; for any other PHY address no PHY register changes.
- R7: Writing the command register with bit 2 set writes the stored transmit data to the addressed PHY register when the PHY address is 1.
- R8: Writes to PHY registers 2 and 3 have no effect.
- R9: PHY register indices at or above 8 ignore writes and read as zero.
- R10: Status bit 0 is the link-failure flag, equal to the inverse of `link_ok`. Every command-register write refreshes it. While command bit 0 (scan) is set, every link change also refreshes it. At all other times it holds its value.
- R11: Host writes to the status register have no effect.
- R12: A command with both bit 2 and bit 1 set returns the value just written in the receive-data register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr_en | input | 1 | Host register write strobe |
| host_sel | input | 3 | Host register select |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Selected host register, combinational |
| link_ok | input | 1 | Link state reported to the PHY model |

## Verification
The bench sweeps all 32 PHY register indices at the implemented address, and all 31 other PHY addresses, both for reads and for writes. A design with a stale default, a writable identifier, or an out-of-range index that aliases onto a real register returns a wrong word. One that responds at a foreign PHY address returns something other than all ones. The link-partner register is preloaded so that the OR and AND masks are observable separately; a wrong mask leaves a visibly wrong bit pattern. The link-failure flag is tested with scan off and with scan on. A flag that tracks the link without scan, or that ignores a command refresh, shows a stale status bit. A combined write and read command that returns the old PHY value exposes a read path taken ahead of the write.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;
  localparam int PHY_W = 16;

  typedef enum logic [2:0] {
    HS_MODE = 3'd0,
    HS_CMD  = 3'd1,
    HS_ADDR = 3'd2,
    HS_TXD  = 3'd3,
    HS_RXD  = 3'd4,
    HS_STAT = 3'd5
  } host_sel_e;

  // PHY register indices whose behaviour is decoded
  localparam int PI_CTRL = 0;
  localparam int PI_STAT = 1;
  localparam int PI_ID1  = 2;
  localparam int PI_ID2  = 3;
  localparam int PI_ADV  = 4;
  localparam int PI_LPA  = 5;

  localparam int CMD_SCAN  = 0;
  localparam int CMD_READ  = 1;
  localparam int CMD_WRITE = 2;

  localparam int LINK_BIT = 2;
  localparam logic [PHY_W-1:0] LPA_UP_OR    = 16'h01E1;
  localparam logic [PHY_W-1:0] LPA_DOWN_AND = 16'h01FF;
  localparam logic [PHY_W-1:0] ID1_DEF      = 16'h2000;
  localparam logic [PHY_W-1:0] ID2_DEF      = 16'h5C90;

  function automatic logic [PHY_W-1:0] phy_default(int idx);
    case (idx)
      PI_CTRL: phy_default = 16'h1000;
      PI_STAT: phy_default = 16'h7848;
      PI_ID1:  phy_default = ID1_DEF;
      PI_ID2:  phy_default = ID2_DEF;
      PI_ADV:  phy_default = 16'h01E1;
      default: phy_default = '0;
    endcase
  endfunction
endpackage

// File: rtl/mgmt_phy_file.sv
module mgmt_phy_file
  import mgmt_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int IDX_W    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [PHY_W-1:0] wr_data,
  input  logic             link_ok,
  output logic [PHY_W-1:0] rd_data,
  output logic             link_chg,
  output logic [PHY_W-1:0] stat_o,
  output logic [PHY_W-1:0] lpa_o,
  output logic [PHY_W-1:0] id1_o,
  output logic [PHY_W-1:0] id2_o
);
  logic [PHY_W-1:0] regs_q [NUM_REGS];
  logic [PHY_W-1:0] regs_d [NUM_REGS];
  logic             link_q;
  logic             upd_en;

  assign link_chg = link_ok != link_q;
  assign upd_en   = wr_en | link_chg;

  always_comb begin
    for (int i = 0; i < NUM_REGS; i++) begin
      regs_d[i] = regs_q[i];
      if (wr_en && idx == IDX_W'(i) && i != PI_ID1 && i != PI_ID2)
        regs_d[i] = wr_data;
    end
    if (link_chg) begin
      if (link_ok) begin
        regs_d[PI_STAT][LINK_BIT] = 1'b1;
        regs_d[PI_LPA] = regs_d[PI_LPA] | LPA_UP_OR;
      end else begin
        regs_d[PI_STAT][LINK_BIT] = 1'b0;
        regs_d[PI_LPA] = regs_d[PI_LPA] & LPA_DOWN_AND;
      end
    end
  end

  // read port sees the post-update view so a combined command reads its own write
  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (idx == IDX_W'(i)) rd_data = regs_d[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= phy_default(i);
      link_q <= 1'b0;
    end else begin
      link_q <= link_ok;
      if (upd_en)
        for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= regs_d[i];
    end
  end

  assign stat_o = regs_q[PI_STAT];
  assign lpa_o  = regs_q[PI_LPA];
  assign id1_o  = regs_q[PI_ID1];
  assign id2_o  = regs_q[PI_ID2];
endmodule

// File: rtl/mgmt_host_regs.sv
module mgmt_host_regs
  import mgmt_pkg::*;
#(
  parameter int          HOST_W   = 32,
  parameter int          ADDR_W   = 5,
  parameter int          RGAD_LSB = 8,
  parameter int          PHY_ADDR = 1,
  parameter logic [31:0] MODE_RST = 32'h64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        sel,
  input  logic [HOST_W-1:0] wdata,
  output logic [HOST_W-1:0] rdata,
  input  logic              link_ok,
  input  logic              link_chg,
  input  logic [PHY_W-1:0]  phy_rd_data,
  output logic              phy_wr_en,
  output logic [ADDR_W-1:0] phy_idx,
  output logic [PHY_W-1:0]  phy_wr_data,
  output logic [PHY_W-1:0]  rx_o,
  output logic              fail_o,
  output logic [ADDR_W-1:0] fiad_o
);
  logic [HOST_W-1:0] mode_q, mode_d;
  logic [2:0]        cmd_q, cmd_d;
  logic [ADDR_W-1:0] fiad_q, fiad_d, rgad_q, rgad_d;
  logic [PHY_W-1:0]  tx_q, tx_d, rx_q, rx_d;
  logic              fail_q, fail_d;
  logic              cmd_wr, tx_wr, match;

  assign cmd_wr = wr_en && sel == HS_CMD;
  assign tx_wr  = wr_en && sel == HS_TXD;
  assign match  = fiad_q == ADDR_W'(PHY_ADDR);

  assign phy_idx     = rgad_q;
  assign phy_wr_en   = match && (tx_wr || (cmd_wr && wdata[CMD_WRITE]));
  assign phy_wr_data = tx_wr ? wdata[PHY_W-1:0] : tx_q;

  always_comb begin
    mode_d = mode_q;
    cmd_d  = cmd_q;
    fiad_d = fiad_q;
    rgad_d = rgad_q;
    tx_d   = tx_q;
    rx_d   = rx_q;
    fail_d = fail_q;
    if (wr_en && sel == HS_MODE) mode_d = wdata;
    if (wr_en && sel == HS_ADDR) begin
      fiad_d = wdata[ADDR_W-1:0];
      rgad_d = wdata[RGAD_LSB +: ADDR_W];
    end
    if (tx_wr) tx_d = wdata[PHY_W-1:0];
    if (cmd_wr) begin
      cmd_d  = wdata[2:0];
      fail_d = ~link_ok;
      if (wdata[CMD_READ]) rx_d = match ? phy_rd_data : '1;
    end else if (link_chg && cmd_q[CMD_SCAN]) begin
      fail_d = ~link_ok;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= HOST_W'(MODE_RST);
      cmd_q  <= '0;
      fiad_q <= '0;
      rgad_q <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
      fail_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      cmd_q  <= cmd_d;
      fiad_q <= fiad_d;
      rgad_q <= rgad_d;
      tx_q   <= tx_d;
      rx_q   <= rx_d;
      fail_q <= fail_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (sel)
      HS_MODE: rdata = mode_q;
      HS_CMD:  rdata[2:0] = cmd_q;
      HS_ADDR: begin
        rdata[ADDR_W-1:0] = fiad_q;
        rdata[RGAD_LSB +: ADDR_W] = rgad_q;
      end
      HS_TXD:  rdata[PHY_W-1:0] = tx_q;
      HS_RXD:  rdata[PHY_W-1:0] = rx_q;
      HS_STAT: rdata[0] = fail_q;
      default: rdata = '0;
    endcase
  end

  assign rx_o   = rx_q;
  assign fail_o = fail_q;
  assign fiad_o = fiad_q;
endmodule

// File: rtl/mgmt_phy_regs.sv
module mgmt_phy_regs
  import mgmt_pkg::*;
#(
  parameter int NUM_PHY_REGS = 8,
  parameter int PHY_ADDR     = 1,
  parameter int ADDR_W       = 5,
  parameter int HOST_W       = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr_en,
  input  logic [2:0]        host_sel,
  input  logic [HOST_W-1:0] host_wdata,
  output logic [HOST_W-1:0] host_rdata,
  input  logic              link_ok
);
  logic              phy_wr_en, link_chg, link_fail;
  logic [ADDR_W-1:0] phy_idx, fiad;
  logic [PHY_W-1:0]  phy_wr_data, phy_rd_data, rx_data;
  logic [PHY_W-1:0]  phy_stat, phy_lpa, phy_id1, phy_id2;

  mgmt_host_regs #(
    .HOST_W(HOST_W), .ADDR_W(ADDR_W), .RGAD_LSB(8),
    .PHY_ADDR(PHY_ADDR), .MODE_RST(32'h64)
  ) u_host (
    .clk(clk), .rst_n(rst_n), .wr_en(host_wr_en), .sel(host_sel),
    .wdata(host_wdata), .rdata(host_rdata), .link_ok(link_ok),
    .link_chg(link_chg), .phy_rd_data(phy_rd_data), .phy_wr_en(phy_wr_en),
    .phy_idx(phy_idx), .phy_wr_data(phy_wr_data), .rx_o(rx_data),
    .fail_o(link_fail), .fiad_o(fiad)
  );

  mgmt_phy_file #(.NUM_REGS(NUM_PHY_REGS), .IDX_W(ADDR_W)) u_phy (
    .clk(clk), .rst_n(rst_n), .wr_en(phy_wr_en), .idx(phy_idx),
    .wr_data(phy_wr_data), .link_ok(link_ok), .rd_data(phy_rd_data),
    .link_chg(link_chg), .stat_o(phy_stat), .lpa_o(phy_lpa),
    .id1_o(phy_id1), .id2_o(phy_id2)
  );
endmodule

// File: rtl/mgmt_checker.sv
module mgmt_checker
  import mgmt_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int HOST_W   = 32,
  parameter int PHY_ADDR = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_wr_en,
  input logic [2:0]        host_sel,
  input logic [HOST_W-1:0] host_wdata,
  input logic              link_ok,
  input logic              link_chg,
  input logic              link_fail,
  input logic [ADDR_W-1:0] fiad,
  input logic [PHY_W-1:0]  rx_data,
  input logic [PHY_W-1:0]  phy_stat,
  input logic [PHY_W-1:0]  phy_lpa,
  input logic [PHY_W-1:0]  phy_id1,
  input logic [PHY_W-1:0]  phy_id2
);
  AST_LINK_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    link_chg |=> phy_stat[LINK_BIT] == $past(link_ok)); // R5
  AST_LPA_UP: assert property (@(posedge clk) disable iff (!rst_n)
    link_chg && link_ok |=> (phy_lpa & LPA_UP_OR) == LPA_UP_OR); // R5
  AST_LPA_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    link_chg && !link_ok |=> (phy_lpa & ~LPA_DOWN_AND) == '0); // R5
  AST_ID_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    phy_id1 == ID1_DEF && phy_id2 == ID2_DEF); // R8
  AST_MISS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr_en && host_sel == HS_CMD && host_wdata[CMD_READ] &&
    fiad != ADDR_W'(PHY_ADDR) |=> rx_data == 16'hFFFF); // R4
  AST_FAIL_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr_en && host_sel == HS_CMD |=> link_fail == !$past(link_ok)); // R10
  AST_STAT_RO: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr_en && host_sel == HS_STAT && !link_chg |=> $stable(link_fail)); // R11
endmodule

bind mgmt_phy_regs mgmt_checker #(
  .ADDR_W(ADDR_W), .HOST_W(HOST_W), .PHY_ADDR(PHY_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .host_wr_en(host_wr_en), .host_sel(host_sel),
  .host_wdata(host_wdata), .link_ok(link_ok), .link_chg(link_chg),
  .link_fail(link_fail), .fiad(fiad), .rx_data(rx_data),
  .phy_stat(phy_stat), .phy_lpa(phy_lpa), .phy_id1(phy_id1), .phy_id2(phy_id2)
);

// File: tb/tb_mgmt_phy_regs.sv
`timescale 1ns/1ps
module tb_mgmt_phy_regs;
  logic        clk, rst_n, wr_en, link;
  logic [2:0]  sel;
  logic [31:0] wdata, rdata;
  int checks, errors;
  bit done;

  mgmt_phy_regs dut (
    .clk(clk), .rst_n(rst_n), .host_wr_en(wr_en), .host_sel(sel),
    .host_wdata(wdata), .host_rdata(rdata), .link_ok(link)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hwr(logic [2:0] s, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; sel = s; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic hrd(logic [2:0] s, output logic [31:0] d);
    @(negedge clk);
    sel = s;
    #1 d = rdata;
  endtask

  task automatic set_addr(int fiad, int rgad);
    hwr(3'd2, 32'((rgad << 8) | fiad));
  endtask

  task automatic phy_read(int idx, output logic [31:0] d);
    set_addr(1, idx);
    hwr(3'd1, 32'h2);
    hrd(3'd4, d);
  endtask

  task automatic set_link(logic v);
    @(negedge clk);
    link = v;
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [15:0] def_val(int idx);
    case (idx)
      0: def_val = 16'h1000;
      1: def_val = 16'h7848;
      2: def_val = 16'h2000;
      3: def_val = 16'h5C90;
      4: def_val = 16'h01E1;
      default: def_val = 16'h0000;
    endcase
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [15:0] v;
    checks = 0; errors = 0; done = 0;
    rst_n = 1'b0; wr_en = 1'b0; sel = '0; wdata = '0; link = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state of host registers
    hrd(3'd0, r); chk("R1 mode reset", r, 32'h64);
    for (int s = 1; s < 8; s++) begin
      hrd(3'(s), r); chk("R1 reset zero", r, 32'h0);
    end
    hwr(3'd0, 32'hDEAD_BEEF);
    hrd(3'd0, r); chk("R1 mode write", r, 32'hDEAD_BEEF);

    // R2 address fields
    hwr(3'd2, 32'hFFFF_FFFF);
    hrd(3'd2, r); chk("R2 addr fields", r, 32'h0000_1F1F);

    // R3 R9 default sweep at the implemented address
    for (int i = 0; i < 32; i++) begin
      phy_read(i, r); chk("R3 default", r, {16'h0, def_val(i)});
    end

    // R4 foreign PHY addresses read all ones
    for (int f = 0; f < 32; f++) begin
      if (f != 1) begin
        set_addr(f, 0);
        hwr(3'd1, 32'h2);
        hrd(3'd4, r); chk("R4 foreign addr", r, 32'h0000_FFFF);
      end
    end

    // R6 writes to a foreign address change nothing
    for (int f = 0; f < 32; f++) begin
      if (f != 1) begin
        set_addr(f, 4);
        hwr(3'd3, 32'h0000_1234);
      end
    end
    hrd(3'd3, r); chk("R6 txdata stored", r, 32'h0000_1234);
    phy_read(4, r); chk("R6 foreign write ignored", r, 32'h0000_01E1);

    // R6 R8 R9 write sweep via transmit data at address 1
    for (int i = 0; i < 32; i++) begin
      v = 16'hA500 ^ 16'(i);
      set_addr(1, i);
      hwr(3'd3, {16'hFFFF, v});
      phy_read(i, r);
      if (i == 2 || i == 3) chk("R8 id write ignored", r, {16'h0, def_val(i)});
      else if (i >= 8)      chk("R9 out of range", r, 32'h0);
      else                  chk("R6 txdata write", r, {16'h0, v});
    end

    // R7 command write uses stored transmit data
    set_addr(0, 0);
    hwr(3'd3, 32'h0000_5A5A);
    set_addr(1, 0);
    hwr(3'd1, 32'h4);
    phy_read(0, r); chk("R7 command write", r, 32'h0000_5A5A);

    // R12 combined write and read returns the written value
    set_addr(0, 0);
    hwr(3'd3, 32'h0000_C3C3);
    set_addr(1, 6);
    hwr(3'd1, 32'h6);
    hrd(3'd4, r); chk("R12 combined cmd", r, 32'h0000_C3C3);

    // R5 link reflection with preloaded partner ability
    set_addr(1, 5);
    hwr(3'd3, 32'h0000_3C00);
    phy_read(5, r); chk("R5 lpa preload", r, 32'h0000_3C00);
    set_link(1'b1);
    phy_read(1, r); chk("R5 status up", r, 32'h0000_A505);
    phy_read(5, r); chk("R5 lpa up", r, 32'h0000_3DE1);
    set_link(1'b0);
    phy_read(1, r); chk("R5 status down", r, 32'h0000_A501);
    phy_read(5, r); chk("R5 lpa down", r, 32'h0000_01E1);

    // R10 R11 link failure flag
    hwr(3'd1, 32'h0);
    hrd(3'd5, r); chk("R10 cmd refresh down", r, 32'h1);
    set_link(1'b1);
    hrd(3'd5, r); chk("R10 no scan holds", r, 32'h1);
    hwr(3'd1, 32'h1);
    hrd(3'd5, r); chk("R10 cmd refresh up", r, 32'h0);
    set_link(1'b0);
    hrd(3'd5, r); chk("R10 scan down", r, 32'h1);
    hwr(3'd5, 32'h0);
    hrd(3'd5, r); chk("R11 status write ignored", r, 32'h1);
    set_link(1'b1);
    hrd(3'd5, r); chk("R10 scan up", r, 32'h0);
    hwr(3'd5, 32'hFFFF_FFFF);
    hrd(3'd5, r); chk("R11 status write ignored", r, 32'h0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule